// File: doc/BRIEF.md
# Timer clock prescaler with select

The block turns a fast clock into a single-cycle count-enable tick for a downstream timer. A 4-bit select input chooses the divide ratio, and one select value parks the prescaler so that no ticks are issued, which gives the timer its on/off control. All ratios are powers of two and share one free-running count of 1024 states. For a ratio N, the tick is high in every cycle where that count, taken modulo N, equals N-1.

Software can restart the prescaler phase by writing one to a reset bit through a write strobe and data bit. The write clears the shared count in the clock edge that accepts it. Nothing else changes, and the timer value downstream is never touched. The reset bit clears itself, so the read-back of that bit is always zero. Changing the select code does not restart the count. The new ratio simply taps the running count from the next cycle on.

Top module: `prescale_tick_gen`

## Requirements
- R1: Select code 4'b0000 holds tick_o low in every cycle and freezes the shared count. When a non-zero code is chosen again, counting resumes from the held value.
- R2: Select codes 4'b0001 to 4'b0111 give divide ratios 1, 2, 4, 8, 16, 32 and 64. The ratio is 2^(code-1).
- R3: Select codes 4'b1000 to 4'b1111 give divide ratios 8, 16, 32, 64, 128, 256, 512 and 1024. The ratio is 2^(code[2:0]+3).
- R4: A cycle with psr_we_i=1 and psr_wdata_i=1 sets the shared count to 0 at that clock edge. With ratio N>1, the first tick afterwards comes exactly N cycles after the edge.
- R5: A cycle with psr_we_i=1 and psr_wdata_i=0 has no effect. The count advances as if no write had occurred.
- R6: psr_rdata_o reads 0 in every cycle, including the cycle of a reset write.
- R7: With any ratio above 1, tick_o is high for exactly one cycle per period. With ratio 1, tick_o is high in every cycle.
- R8: A change of select code does not clear the count. With ratio N, tick_o is high when (count mod N) = N-1, where the count is 0 after reset and after R4 and otherwise advances by one each cycle modulo 1024.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast source clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 4 | Divide select code |
| psr_we_i | input | 1 | Write strobe for the prescaler reset bit |
| psr_wdata_i | input | 1 | Data written to the prescaler reset bit |
| tick_o | output | 1 | Count-enable tick, one clock wide |
| psr_rdata_o | output | 1 | Read-back of the prescaler reset bit, always 0 |

## Verification
The only internal state is the shared count, and tick_o depends on it in every cycle. A count that skips, sticks or clears at the wrong moment therefore moves the next tick of a small ratio within a few cycles, and moves the tick of a large ratio by the end of the current period. Stop and reset writes are mixed at random with select changes. This way a wrong hold, a missed clear or a clear on a zero write puts the tick phase out of line within one period of the active ratio.

// File: rtl/prescale_pkg.sv
package prescale_pkg;
  localparam int unsigned SEL_W = 4;
  localparam logic [SEL_W-1:0] SEL_STOP = '0;

  // log2 of the divide ratio; high half of the code map restarts at 8
  function automatic int unsigned sel_to_log2(input logic [SEL_W-1:0] s);
    if (s[SEL_W-1]) return int'(s[SEL_W-2:0]) + 3;
    else if (s == SEL_STOP) return 0;
    else return int'(s[SEL_W-2:0]) - 1;
  endfunction
endpackage

// File: rtl/prescale_sel_decode.sv
module prescale_sel_decode import prescale_pkg::*; #(
  parameter int unsigned CNT_W = 10
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic             run_o,
  output logic [CNT_W-1:0] mask_o
);
  int unsigned k;

  always_comb k = sel_to_log2(sel_i);
  assign run_o = (sel_i != SEL_STOP);

  for (genvar i = 0; i < CNT_W; i++) begin : g_mask
    assign mask_o[i] = (i < k);
  end
endmodule

// File: rtl/prescale_count.sv
module prescale_count #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (run_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  p_zero_write_noop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && run_i) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/prescale_tap.sv
module prescale_tap #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             run_i,
  input  logic [CNT_W-1:0] mask_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             tick_o
);
  assign tick_o = run_i && ((cnt_i & mask_i) == mask_i);
endmodule

// File: rtl/prescale_tick_gen.sv
module prescale_tick_gen import prescale_pkg::*; #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             psr_we_i,
  input  logic             psr_wdata_i,
  output logic             tick_o,
  output logic             psr_rdata_o
);
  logic             run;
  logic             clr;
  logic [CNT_W-1:0] mask;
  logic [CNT_W-1:0] cnt;

  assign clr = psr_we_i && psr_wdata_i;

  prescale_sel_decode #(.CNT_W(CNT_W)) u_decode (
    .sel_i  (sel_i),
    .run_o  (run),
    .mask_o (mask)
  );

  prescale_count #(.CNT_W(CNT_W)) u_count (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .run_i  (run),
    .cnt_o  (cnt)
  );

  prescale_tap #(.CNT_W(CNT_W)) u_tap (
    .run_i  (run),
    .mask_i (mask),
    .cnt_i  (cnt),
    .tick_o (tick_o)
  );

  // self-clearing: the clear lands in the accepting edge, nothing is stored
  assign psr_rdata_o = 1'b0;

  p_stop_no_tick_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == SEL_STOP) |-> !tick_o);
  p_stop_holds_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == SEL_STOP && !clr) |=> $stable(cnt));
  p_div1_every_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 4'b0001) |-> tick_o);
  p_clear_count_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> (cnt == '0));
  p_no_tick_after_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr && sel_i[SEL_W-1]) |=> !tick_o);
  p_single_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && sel_i[SEL_W-1] && !clr) |=> !tick_o);
endmodule

// File: tb/prescale_tick_gen_bench.sv
module prescale_tick_gen_bench;
  localparam int unsigned CLK_P = 10;
  localparam int unsigned MOD   = 1024;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] sel = 4'b0000;
  logic       we = 1'b0;
  logic       wd = 1'b0;
  logic       tick;
  logic       rdata;

  int unsigned ref_cnt = 0;
  int          n_chk = 0;
  int          n_bad = 0;
  string       force_tag = "";
  logic        prev_tick = 1'b0;
  logic [3:0]  prev_sel = 4'b0000;

  always #(CLK_P/2) clk = ~clk;

  prescale_tick_gen u_prescale_tick_gen (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .sel_i       (sel),
    .psr_we_i    (we),
    .psr_wdata_i (wd),
    .tick_o      (tick),
    .psr_rdata_o (rdata)
  );

  function automatic int unsigned ratio_of(input logic [3:0] s);
    if (s == 4'b0000) return 0;
    if (s[3]) return 8 << s[2:0];
    return 1 << (s[2:0] - 1);
  endfunction

  function automatic logic exp_tick(input logic [3:0] s, input int unsigned c);
    int unsigned r = ratio_of(s);
    if (r == 0) return 1'b0;
    return (c % r) == (r - 1);
  endfunction

  function automatic string tag_of(input logic [3:0] s);
    if (force_tag != "") return force_tag;
    if (s == 4'b0000) return "R1";
    if (s[3]) return "R3";
    return "R2";
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b (sel=%b ref=%0d)", tag, act, exp, sel, ref_cnt);
    end
  endtask

  // one cycle: inputs already set after a falling edge
  task automatic step();
    logic e;
    #1;
    e = exp_tick(sel, ref_cnt);
    check(tag_of(sel), tick, e);
    check("R6", rdata, 1'b0);
    if (prev_tick && tick && sel == prev_sel && ratio_of(sel) > 1)
      check("R7", 1'b1, 1'b0);
    prev_tick = tick;
    prev_sel  = sel;
    @(posedge clk);
    if (we && wd) ref_cnt = 0;
    else if (sel != 4'b0000) ref_cnt = (ref_cnt + 1) % MOD;
    @(negedge clk);
  endtask

  task automatic psr_write(input logic v);
    we = 1'b1; wd = v;
    step();
    we = 1'b0; wd = 1'b0;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    #(CLK_P*2);
    #1;
    check("R6", rdata, 1'b0);   // reset state
    check("R1", tick, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: stop holds the count
    for (int i = 0; i < 5; i++) step();

    // R2/R3: every code, after a clear (R4)
    for (int s = 1; s < 16; s++) begin
      sel = 4'(s);
      psr_write(1'b1);
      force_tag = "R4";
      step();
      force_tag = "";
      for (int i = 0; i < 2*ratio_of(sel) + 2; i++) step();
    end

    // R1: stop mid-period, then resume
    sel = 4'b0100;
    for (int i = 0; i < 3; i++) step();
    sel = 4'b0000;
    for (int i = 0; i < 7; i++) step();
    force_tag = "R1";
    sel = 4'b0100;
    for (int i = 0; i < 10; i++) step();
    force_tag = "";

    // R8: select change keeps the phase
    force_tag = "R8";
    sel = 4'b1000;
    for (int i = 0; i < 5; i++) step();
    sel = 4'b0011;
    for (int i = 0; i < 9; i++) step();
    sel = 4'b1010;
    for (int i = 0; i < 40; i++) step();

    // R5: zero writes change nothing
    force_tag = "R5";
    sel = 4'b0101;
    for (int i = 0; i < 6; i++) begin
      psr_write(1'b0);
      step();
    end
    force_tag = "";

    // R6 during a clear write
    psr_write(1'b1);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 49) == 0) sel = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 29) == 0) begin
        force_tag = "R4";
        psr_write(1'($urandom_range(0, 1)));
        force_tag = "";
      end else begin
        step();
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule